// File: doc/BRIEF.md
# Hash Offload Command and Status Registers

This block is the software-facing front end of a hash offload engine. A processor writes a source address, a destination address, a source length and a command word through a simple 32-bit register port. The command word carries a two-level algorithm code, a scatter-gather source flag and an interrupt enable. When the code names a supported algorithm and the engine is idle, the block sends a one-cycle start pulse to the engine, together with the decoded algorithm and the scatter-gather flag. It holds the engine busy until the engine reports completion.

Completion always sets a sticky done flag in the status word. The level interrupt output is raised only when the accepted command had its interrupt enable set. Software clears the done flag and the interrupt together by writing one to the done bit. The hashing datapath and the memory master sit outside this block. They see only the start pulse, the decoded fields, the stored addresses and length, and a done input.

Top module: `hce_ctrl_top`

## Requirements
- R1: After reset, every register reads zero and irq and eng_start are low.
- R2: Registers are word addressed at byte offsets 0x1C (status), 0x20 (source address), 0x24 (destination address), 0x2C (length) and 0x30 (command). A read returns data on bus_rdata in the cycle after the request. Reads of unmapped words, of misaligned addresses (address bits [1:0] not zero) and of addresses at or beyond 0x40 return zero.
- R3: Writes at or beyond byte offset 0x40, or to a misaligned address, change no register.
- R4: Written values are masked before they are stored: source with 0x7FFFFFFF, destination with 0x7FFFFFF8, length with 0x0FFFFFFF and command with 0x00147FFF. The stored source, destination and length drive eng_src, eng_dst and eng_len.
- R5: The algorithm code is command bits [6:4] with bits [12:10] zero. 000 gives eng_algo 0 (MD5), 010 gives 1 (SHA1), 100 gives 2 (SHA224) and 101 gives 3 (SHA256).
- R6: Code 110 in bits [6:4] selects the 512-bit family, and bits [12:10] then pick the variant. 000 gives eng_algo 4 (SHA512), 001 gives 5 (SHA384), 010 gives 6 (512-bit engine truncated to 256) and 011 gives 7 (truncated to 224).
- R7: Any other combination of bits [6:4] and [12:10] is refused. The command word is still stored, but no start pulse occurs, busy stays clear and no interrupt follows.
- R8: A valid command written while idle gives eng_start high for exactly the one cycle after the write. eng_algo and eng_sg (command bit 18) are valid with it, and status bit 0 (busy) reads one until completion.
- R9: A command write while busy is ignored. The stored command keeps its old value and no start pulse occurs.
- R10: eng_done while busy sets status bit 9 and clears busy, whether or not the interrupt is enabled.
- R11: irq goes high on completion only when command bit 9 was set in the accepted command, and it stays high until cleared.
- R12: Writing status with bit 9 set clears the done bit and drops irq. Writing status with bit 9 zero changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_algo | output | 3 | Decoded algorithm code |
| eng_sg | output | 1 | Scatter-gather source mode |
| eng_src | output | 32 | Stored source address |
| eng_dst | output | 32 | Stored destination address |
| eng_len | output | 32 | Stored source length |
| eng_done | input | 1 | Engine completion pulse |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a command write that arrives while an earlier job is still running, because the engine side has to be held off on purpose. The bench drives eng_done itself. It launches a job, then writes a different command before pulsing done, and checks that the readback and the start line are unchanged. Random command words lean toward the few valid codes and toward a zero sub-field, so both acceptance and refusal occur often. A write that lands just past the register range is used to catch address decoding that wraps around.

// File: rtl/hce_pkg.sv
package hce_pkg;

    localparam int unsigned DATA_W = 32;

    // word indices of the mapped registers (byte offset / 4)
    localparam int unsigned IDX_STATUS = 7;
    localparam int unsigned IDX_SRC    = 8;
    localparam int unsigned IDX_DST    = 9;
    localparam int unsigned IDX_LEN    = 11;
    localparam int unsigned IDX_CMD    = 12;

    localparam logic [DATA_W-1:0] MASK_SRC = 32'h7FFF_FFFF;
    localparam logic [DATA_W-1:0] MASK_DST = 32'h7FFF_FFF8;
    localparam logic [DATA_W-1:0] MASK_LEN = 32'h0FFF_FFFF;
    localparam logic [DATA_W-1:0] MASK_CMD = 32'h0014_7FFF;

    localparam int unsigned CMD_IE_BIT  = 9;
    localparam int unsigned CMD_SG_BIT  = 18;
    localparam int unsigned ST_DONE_BIT = 9;
    localparam int unsigned ST_BUSY_BIT = 0;

    typedef enum logic [2:0] {
        ALG_MD5        = 3'd0,
        ALG_SHA1       = 3'd1,
        ALG_SHA224     = 3'd2,
        ALG_SHA256     = 3'd3,
        ALG_SHA512     = 3'd4,
        ALG_SHA384     = 3'd5,
        ALG_SHA512_256 = 3'd6,
        ALG_SHA512_224 = 3'd7
    } hce_algo_e;

    typedef struct packed {
        logic      busy;
        logic      done;
        logic      irq;
        logic      start;
        hce_algo_e algo;
        logic      sg;
        logic      ie;
    } hce_ctl_t;

endpackage

// File: rtl/hce_cmd_decode.sv
module hce_cmd_decode
    import hce_pkg::*;
(
    input  logic [2:0] fam,
    input  logic [2:0] sub,
    output logic       valid,
    output hce_algo_e  algo
);

    always_comb begin
        valid = 1'b0;
        algo  = ALG_MD5;
        unique case (fam)
            3'b000: begin valid = (sub == 3'b000); algo = ALG_MD5;    end
            3'b010: begin valid = (sub == 3'b000); algo = ALG_SHA1;   end
            3'b100: begin valid = (sub == 3'b000); algo = ALG_SHA224; end
            3'b101: begin valid = (sub == 3'b000); algo = ALG_SHA256; end
            3'b110: begin
                unique case (sub)
                    3'b000: begin valid = 1'b1; algo = ALG_SHA512;     end
                    3'b001: begin valid = 1'b1; algo = ALG_SHA384;     end
                    3'b010: begin valid = 1'b1; algo = ALG_SHA512_256; end
                    3'b011: begin valid = 1'b1; algo = ALG_SHA512_224; end
                    default: begin valid = 1'b0; algo = ALG_MD5;       end
                endcase
            end
            default: begin valid = 1'b0; algo = ALG_MD5; end
        endcase
    end

endmodule

// File: rtl/hce_field_reg.sv
module hce_field_reg #(
    parameter int unsigned          W    = 32,
    parameter logic [W-1:0]         MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we) begin
            val_d = wdata & MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/hce_status_ctrl.sv
module hce_status_ctrl
    import hce_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      launch,
    input  hce_algo_e launch_algo,
    input  logic      launch_sg,
    input  logic      launch_ie,
    input  logic      eng_done,
    input  logic      clr_done,
    output logic      busy,
    output logic      done,
    output logic      irq,
    output logic      start,
    output hce_algo_e algo,
    output logic      sg
);

    hce_ctl_t ctl_d, ctl_q;
    logic     finish;

    assign finish = eng_done && ctl_q.busy;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;

        if (launch && !ctl_q.busy) begin
            ctl_d.busy  = 1'b1;
            ctl_d.start = 1'b1;
            ctl_d.algo  = launch_algo;
            ctl_d.sg    = launch_sg;
            ctl_d.ie    = launch_ie;
        end

        // software clear first, so a completion in the same cycle wins
        if (clr_done) begin
            ctl_d.done = 1'b0;
            ctl_d.irq  = 1'b0;
        end

        if (finish) begin
            ctl_d.busy = 1'b0;
            ctl_d.done = 1'b1;
            if (ctl_q.ie) begin
                ctl_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy  = ctl_q.busy;
    assign done  = ctl_q.done;
    assign irq   = ctl_q.irq;
    assign start = ctl_q.start;
    assign algo  = ctl_q.algo;
    assign sg    = ctl_q.sg;

endmodule

// File: rtl/hce_ctrl_top.sv
module hce_ctrl_top
    import hce_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned REG_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_start,
    output logic [2:0]        eng_algo,
    output logic              eng_sg,
    output logic [31:0]       eng_src,
    output logic [31:0]       eng_dst,
    output logic [31:0]       eng_len,
    input  logic              eng_done,
    output logic              irq
);

    localparam int unsigned IDX_W  = ADDR_W - 2;
    localparam int unsigned N_REGS = 4;
    localparam int unsigned REG_IDX  [N_REGS] = '{IDX_SRC, IDX_DST, IDX_LEN, IDX_CMD};
    localparam logic [31:0] REG_MASK [N_REGS] = '{MASK_SRC, MASK_DST, MASK_LEN, MASK_CMD};
    localparam int unsigned SLOT_CMD = 3;

    logic [IDX_W-1:0] word_idx;
    logic             in_range;
    logic             hit_status;
    logic [N_REGS-1:0] reg_hit;
    logic [N_REGS-1:0] reg_we;
    logic [31:0]      reg_q [N_REGS];

    logic             st_busy, st_done, st_sg;
    hce_algo_e        st_algo;
    logic             dec_valid;
    hce_algo_e        dec_algo;
    logic             launch;
    logic             clr_done;
    logic [31:0]      cmd_masked;

    logic [31:0]      rdata_d, rdata_q;
    logic [31:0]      rd_val;

    assign word_idx   = bus_addr[ADDR_W-1:2];
    assign in_range   = (bus_addr[1:0] == 2'b00) && (int'(word_idx) < REG_WORDS);
    assign hit_status = in_range && (int'(word_idx) == IDX_STATUS);

    generate
        for (genvar i = 0; i < N_REGS; i++) begin : g_reg
            assign reg_hit[i] = in_range && (int'(word_idx) == REG_IDX[i]);
            if (i == SLOT_CMD) begin : g_cmd_we
                assign reg_we[i] = bus_valid && bus_write && reg_hit[i] && !st_busy;
            end else begin : g_plain_we
                assign reg_we[i] = bus_valid && bus_write && reg_hit[i];
            end
            hce_field_reg #(
                .W    (32),
                .MASK (REG_MASK[i])
            ) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (reg_we[i]),
                .wdata (bus_wdata),
                .q     (reg_q[i])
            );
        end
    endgenerate

    assign cmd_masked = bus_wdata & MASK_CMD;

    hce_cmd_decode u_dec (
        .fam   (cmd_masked[6:4]),
        .sub   (cmd_masked[12:10]),
        .valid (dec_valid),
        .algo  (dec_algo)
    );

    assign launch   = reg_we[SLOT_CMD] && dec_valid;
    assign clr_done = bus_valid && bus_write && hit_status && bus_wdata[ST_DONE_BIT];

    hce_status_ctrl u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_algo (dec_algo),
        .launch_sg   (cmd_masked[CMD_SG_BIT]),
        .launch_ie   (cmd_masked[CMD_IE_BIT]),
        .eng_done    (eng_done),
        .clr_done    (clr_done),
        .busy        (st_busy),
        .done        (st_done),
        .irq         (irq),
        .start       (eng_start),
        .algo        (st_algo),
        .sg          (st_sg)
    );

    always_comb begin
        rd_val = '0;
        if (hit_status) begin
            rd_val[ST_DONE_BIT] = st_done;
            rd_val[ST_BUSY_BIT] = st_busy;
        end
        for (int i = 0; i < N_REGS; i++) begin
            if (reg_hit[i]) begin
                rd_val = reg_q[i];
            end
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_valid && !bus_write) begin
            rdata_d = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;
    assign eng_algo  = st_algo;
    assign eng_sg    = st_sg;
    assign eng_src   = reg_q[0];
    assign eng_dst   = reg_q[1];
    assign eng_len   = reg_q[2];

endmodule

// File: rtl/hce_ctrl_chk.sv
module hce_ctrl_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              eng_start,
    input logic              eng_done,
    input logic              irq,
    input logic              busy,
    input logic              done
);

    logic status_clear;
    assign status_clear = bus_valid && bus_write && (bus_addr == ADDR_W'(12'h01C)) && bus_wdata[9];

    // R8: the launch pulse lasts one cycle and marks the engine busy
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    // R9: no launch while a job is already running
    a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !eng_start);

    // R10: completion while busy sets done and frees the engine
    a_r10_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && busy) |=> (done && !busy));

    // R11: interrupt only alongside a pending done, and only after completion
    a_r11_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    a_r11_irq_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(eng_done));

    // R12: write-one clear drops the flag and the line
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clear && !eng_done) |=> (!irq && !done));

endmodule

bind hce_ctrl_top hce_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .irq       (irq),
    .busy      (st_busy),
    .done      (st_done)
);

// File: tb/sim_hce_ctrl_top.sv
module sim_hce_ctrl_top;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              eng_start;
    logic [2:0]        eng_algo;
    logic              eng_sg;
    logic [31:0]       eng_src, eng_dst, eng_len;
    logic              eng_done = 1'b0;
    logic              irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    hce_ctrl_top #(.ADDR_W(ADDR_W), .REG_WORDS(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_algo(eng_algo), .eng_sg(eng_sg),
        .eng_src(eng_src), .eng_dst(eng_dst), .eng_len(eng_len),
        .eng_done(eng_done), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic        seen_start;
    logic [2:0]  seen_algo;
    logic        seen_sg;

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        seen_start = eng_start; seen_algo = eng_algo; seen_sg = eng_sg;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    // expected decode: returns {valid, code}
    function automatic logic [3:0] ref_decode(input logic [31:0] c);
        logic [2:0] f, s;
        f = c[6:4]; s = c[12:10];
        if (f == 3'b110) begin
            case (s)
                3'b000: return {1'b1, 3'd4};
                3'b001: return {1'b1, 3'd5};
                3'b010: return {1'b1, 3'd6};
                3'b011: return {1'b1, 3'd7};
                default: return 4'd0;
            endcase
        end
        if (s != 3'b000) return 4'd0;
        case (f)
            3'b000: return {1'b1, 3'd0};
            3'b010: return {1'b1, 3'd1};
            3'b100: return {1'b1, 3'd2};
            3'b101: return {1'b1, 3'd3};
            default: return 4'd0;
        endcase
    endfunction

    // full command round: write, check launch, finish, check irq and status
    task automatic run_cmd(input logic [31:0] c);
        logic [3:0]  e;
        logic [31:0] r;
        e = ref_decode(c & 32'h0014_7FFF);
        wr(12'h030, c);
        check(e[3] ? "R8 start" : "R7 refused start", {31'd0, seen_start}, {31'd0, e[3]});
        rd(12'h030, r);
        check("R4 cmd mask", r, c & 32'h0014_7FFF);
        if (e[3]) begin
            check(e[2] ? "R6 family algo" : "R5 algo", {29'd0, seen_algo}, {29'd0, e[2:0]});
            check("R8 sg", {31'd0, seen_sg}, {31'd0, c[18]});
            rd(12'h01C, r);
            check("R8 busy bit", r, 32'h1);
            done_pulse();
            check("R11 irq follows enable", {31'd0, irq}, {31'd0, c[9]});
            rd(12'h01C, r);
            check("R10 done bit", r, 32'h200);
            wr(12'h01C, 32'h200);
            check("R12 clear irq", {31'd0, irq}, 32'd0);
        end else begin
            rd(12'h01C, r);
            check("R7 no busy", r, 32'h0);
            done_pulse();
            check("R7 no irq", {31'd0, irq}, 32'd0);
            rd(12'h01C, r);
            check("R7 done untouched", r, 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, c, v;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 start", {31'd0, eng_start}, 32'd0);
        for (int a = 0; a < 16; a++) begin
            rd(ADDR_W'(a * 4), r);
            check("R1 reg zero", r, 32'd0);
        end

        // R4 masks on data registers
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h024, 32'hFFFF_FFFF);
        wr(12'h02C, 32'hFFFF_FFFF);
        rd(12'h020, r); check("R4 src mask", r, 32'h7FFF_FFFF);
        rd(12'h024, r); check("R4 dst mask", r, 32'h7FFF_FFF8);
        rd(12'h02C, r); check("R4 len mask", r, 32'h0FFF_FFFF);
        check("R4 eng_dst", eng_dst, 32'h7FFF_FFF8);

        // R2 unmapped, misaligned and out-of-range reads
        rd(12'h028, r); check("R2 unmapped", r, 32'd0);
        rd(12'h021, r); check("R2 misaligned", r, 32'd0);
        rd(12'h060, r); check("R2 out of range", r, 32'd0);

        // R3 writes past range (0x60 would wrap onto source) and misaligned
        wr(12'h020, 32'h1234_5678);
        wr(12'h060, 32'h0BAD_0BAD);
        wr(12'h022, 32'h0BAD_0BAD);
        rd(12'h020, r); check("R3 src kept", r, 32'h1234_5678);
        check("R3 eng_src", eng_src, 32'h1234_5678);

        // R5/R6 every valid code, directed
        run_cmd(32'h0000_0200);
        run_cmd(32'h0004_0220);
        run_cmd(32'h0000_0040);
        run_cmd(32'h0000_0250);
        run_cmd(32'h0004_0260);
        run_cmd(32'h0000_0660);
        run_cmd(32'h0000_0A60);
        run_cmd(32'h0000_0E60);
        // R7 refused codes
        run_cmd(32'h0000_0270);
        run_cmd(32'h0000_1260);
        run_cmd(32'h0000_0420);

        // R9 command while busy
        wr(12'h030, 32'h0000_0220);
        check("R9 first start", {31'd0, seen_start}, 32'd1);
        wr(12'h030, 32'h0000_0250);
        check("R9 no second start", {31'd0, seen_start}, 32'd0);
        rd(12'h030, r); check("R9 cmd kept", r, 32'h0000_0220);
        // R12 writing zero leaves done alone
        done_pulse();
        wr(12'h01C, 32'h0000_0001);
        rd(12'h01C, r); check("R12 zero write keeps done", r, 32'h200);
        check("R12 irq kept", {31'd0, irq}, 32'd1);
        wr(12'h01C, 32'h200);
        rd(12'h01C, r); check("R12 cleared", r, 32'h0);

        // R10 done with interrupt disabled
        wr(12'h030, 32'h0000_0010 + 32'h40);
        done_pulse();
        check("R10 no irq when disabled", {31'd0, irq}, 32'd0);
        rd(12'h01C, r); check("R10 done without enable", r, 32'h200);
        wr(12'h01C, 32'h200);

        // random commands and register writes
        for (int n = 0; n < 250; n++) begin
            c = $urandom & 32'h0014_7FFF;
            c[6:4] = ($urandom % 2) ? 3'b110 : 3'($urandom % 8);
            if ($urandom % 2) c[12:10] = 3'b000;
            else if ($urandom % 2) c[12:10] = 3'($urandom % 4);
            c = c | ($urandom & 32'hFFEB_8000);
            run_cmd(c);
            v = $urandom;
            wr(12'h024, v);
            rd(12'h024, r); check("R4 dst random", r, v & 32'h7FFF_FFF8);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule